// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory die. It is clocked by a test clock and steered by a single mode-select line through the standard sixteen-state controller. It has no dedicated test-reset pin. A power-up reset and a run of mode-select ones both bring it back to its reset state. A three-bit instruction register picks the serial data register that sits between the serial input and the serial output. The choices are a one-bit pass-through register, a 32-bit identity word and a boundary register of parameterised length. The instruction register also drives two control lines to the rest of the die. One forces every memory output to high impedance. The other hands the pads over to the boundary update register.

The boundary cells are modelled as a parallel capture bus, sampled in Capture-DR, and a parallel update bus, loaded in Update-DR. Pad electrical behaviour stays outside the block.

Controller states: Test-Logic-Reset, Run-Test/Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR. The transitions, given as the mode-select value at a rising edge, are:
- Reset: 0 goes to Idle, 1 stays in Reset.
- Idle: 1 goes to Select-DR, 0 stays in Idle.
- Select-DR: 1 goes to Select-IR, 0 goes to Capture-DR.
- Select-IR: 1 goes to Reset, 0 goes to Capture-IR.
- Capture: 0 goes to Shift, 1 goes to Exit1.
- Shift: 1 goes to Exit1, 0 stays in Shift.
- Exit1: 1 goes to Update, 0 goes to Pause.
- Pause: 1 goes to Exit2, 0 stays in Pause.
- Exit2: 1 goes to Update, 0 goes back to Shift.
- Update: 1 goes to Select-DR, 0 goes to Idle.

Top module: `tap_port`

## Requirements
- R1: Five consecutive rising test-clock edges with mode-select high bring the controller to Test-Logic-Reset from any state, and the power-up reset also places it there.
- R2: The controller follows the sixteen-state transition table given above, with each move decided by mode-select at a rising test-clock edge.
- R3: Serial input is taken at the rising edge and serial output changes at the falling edge. The output-enable is high exactly while the controller is in Shift-DR or Shift-IR.
- R4: Capture-IR loads binary 001 into the instruction shift stage, so the first three bits shifted out are 1, 0, 0.
- R5: Opcode decode works as follows:
  - 000 selects the boundary register and raises the pad-drive line.
  - 001 selects the identity register.
  - 010 selects the boundary register and raises the force-high-impedance line.
  - 100 selects the boundary register.
  - 011, 101, 110 and 111 select the one-bit pass-through register.
- R6: The active instruction is 001 after power-up and after every entry to Test-Logic-Reset.
- R7: A newly shifted instruction becomes active only through Update-IR. Shifting and pausing leave the active instruction and its control lines unchanged.
- R8: The identity register captures the 32-bit identity parameter with bit 0 forced to 1, and shifts it out least-significant bit first.
- R9: The pass-through register captures 0 and delays the serial input by one shift.
- R10: With a boundary instruction active, Capture-DR loads the pad capture bus and the bits shift out least-significant first. Update-DR then copies the shifted-in bits to the pad update bus, with the first bit shifted in landing in bit 0. Under any other instruction, and in every other state, the pad update bus holds its value.
- R11: The force-high-impedance line is high exactly while opcode 010 is the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| pwr_rst_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Serial output driver enable |
| force_hiz | output | 1 | Forces all memory outputs to high impedance |
| pad_drive | output | 1 | Pads driven from the boundary update bus |
| pad_capture | input | BSR_LEN | Parallel pad levels captured into the boundary register |
| pad_update | output | BSR_LEN | Parallel boundary update values |

## Verification
The assertions assume that mode-select and serial input are stable around each rising test-clock edge. They also assume that the power-up reset is held until the clock has run for a few cycles. The bench changes mode-select and serial input only just after falling edges. It reads the serial output and its enable one time unit after the falling edge that updates them. The bench also holds the pad capture bus constant while a Capture-DR is taking place.

// File: rtl/tap_pkg.sv
package tap_pkg;
    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXT  = 3'b000;
    localparam logic [IR_W-1:0] OP_ID   = 3'b001;
    localparam logic [IR_W-1:0] OP_HIZ  = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMP = 3'b100;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir
);
    tap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state    = state_q;
        in_reset = (state_q == ST_RESET);
        cap_dr   = (state_q == ST_CAP_DR);
        shf_dr   = (state_q == ST_SHF_DR);
        upd_dr   = (state_q == ST_UPD_DR);
        cap_ir   = (state_q == ST_CAP_IR);
        shf_ir   = (state_q == ST_SHF_IR);
        upd_ir   = (state_q == ST_UPD_IR);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap,
    input  logic            shf,
    input  logic            upd,
    output logic [IR_W-1:0] ir_q,
    output logic [IR_W-1:0] ir_sh
);
    localparam logic [IR_W-1:0] CAP_PATTERN = {{(IR_W-2){1'b0}}, 2'b01};

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            ir_sh <= CAP_PATTERN;
            ir_q  <= OP_ID;
        end else begin
            if (cap)      ir_sh <= CAP_PATTERN;
            else if (shf) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            if (in_reset) ir_q  <= OP_ID;
            else if (upd) ir_q  <= ir_sh;
        end
    end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 12,
    parameter logic [31:0] ID_WORD = 32'h0ACE5F72
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  dr_sel_e            sel,
    input  logic               cap,
    input  logic               shf,
    input  logic               upd,
    input  logic [BSR_LEN-1:0] pad_capture,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] pad_update
);
    localparam int          ID_W     = 32;
    localparam logic [ID_W-1:0] ID_FIXED = {ID_WORD[ID_W-1:1], 1'b1};

    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            byp_q      <= 1'b0;
            id_q       <= ID_FIXED;
            bsr_q      <= '0;
            pad_update <= '0;
        end else begin
            unique case (sel)
                SEL_BYP: begin
                    if (cap)      byp_q <= 1'b0;
                    else if (shf) byp_q <= tdi;
                end
                SEL_ID: begin
                    if (cap)      id_q <= ID_FIXED;
                    else if (shf) id_q <= {tdi, id_q[ID_W-1:1]};
                end
                SEL_BSR: begin
                    if (cap)      bsr_q <= pad_capture;
                    else if (shf) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
                    if (upd)      pad_update <= bsr_q;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ID:  dr_lsb = id_q[0];
            SEL_BSR: dr_lsb = bsr_q[0];
            default: dr_lsb = byp_q;
        endcase
    end
endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 12,
    parameter logic [31:0] ID_WORD = 32'h0ACE5F72
) (
    input  logic               tck,
    input  logic               pwr_rst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               force_hiz,
    output logic               pad_drive,
    input  logic [BSR_LEN-1:0] pad_capture,
    output logic [BSR_LEN-1:0] pad_update
);
    tap_state_e      state;
    logic            in_reset, cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir;
    logic [IR_W-1:0] ir_q, ir_sh;
    dr_sel_e         sel;
    logic            dr_lsb;

    tap_fsm u_fsm (
        .tck(tck), .rst_n(pwr_rst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir)
    );

    tap_ir u_ir (
        .tck(tck), .rst_n(pwr_rst_n), .tdi(tdi), .in_reset(in_reset),
        .cap(cap_ir), .shf(shf_ir), .upd(upd_ir), .ir_q(ir_q), .ir_sh(ir_sh)
    );

    always_comb begin
        force_hiz = 1'b0;
        pad_drive = 1'b0;
        unique case (ir_q)
            OP_EXT:  begin sel = SEL_BSR; pad_drive = 1'b1; end
            OP_ID:   sel = SEL_ID;
            OP_HIZ:  begin sel = SEL_BSR; force_hiz = 1'b1; end
            OP_SAMP: sel = SEL_BSR;
            default: sel = SEL_BYP;
        endcase
    end

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .rst_n(pwr_rst_n), .tdi(tdi), .sel(sel),
        .cap(cap_dr), .shf(shf_dr), .upd(upd_dr),
        .pad_capture(pad_capture), .dr_lsb(dr_lsb), .pad_update(pad_update)
    );

    always_ff @(negedge tck or negedge pwr_rst_n) begin
        if (!pwr_rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= shf_ir ? ir_sh[0] : dr_lsb;
            tdo_oe <= shf_ir | shf_dr;
        end
    end
endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
    import tap_pkg::*;
#(
    parameter int BSR_LEN = 12
) (
    input logic               tck,
    input logic               rst_n,
    input logic               tms,
    input tap_state_e         state,
    input logic [IR_W-1:0]    ir_q,
    input logic [IR_W-1:0]    ir_sh,
    input logic               tdo_oe,
    input logic               force_hiz,
    input logic [BSR_LEN-1:0] pad_update
);
    logic [2:0] ones_cnt;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)         ones_cnt <= '0;
        else if (!tms)      ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    p_five_ones_reset_r1: assert property (@(posedge tck) disable iff (!rst_n)
        ones_cnt == 3'd5 |-> state == ST_RESET);

    p_ir_capture_r4: assert property (@(posedge tck) disable iff (!rst_n)
        state == ST_CAP_IR |=> ir_sh == 3'b001);

    p_ir_hold_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q));

    p_oe_shift_r3: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe == (state == ST_SHF_DR || state == ST_SHF_IR));

    p_hiz_via_update_r11: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(force_hiz) |-> $past(state) == ST_UPD_IR);

    p_pad_hold_r10: assert property (@(posedge tck) disable iff (!rst_n)
        state != ST_UPD_DR |=> $stable(pad_update));
endmodule

bind tap_port tap_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck(tck), .rst_n(pwr_rst_n), .tms(tms), .state(state), .ir_q(ir_q),
    .ir_sh(ir_sh), .tdo_oe(tdo_oe), .force_hiz(force_hiz), .pad_update(pad_update)
);

// File: tb/tap_port_bench.sv
module tap_port_bench;
    localparam int          PERIOD  = 10;
    localparam int          BSR_LEN = 12;
    localparam logic [31:0] ID_WORD = 32'h0ACE5F72;
    localparam logic [31:0] ID_EXP  = 32'h0ACE5F73;

    logic               tck = 1'b0;
    logic               pwr_rst_n = 1'b0;
    logic               tms = 1'b1;
    logic               tdi = 1'b1;
    logic               tdo, tdo_oe, force_hiz, pad_drive;
    logic [BSR_LEN-1:0] pad_capture = '0;
    logic [BSR_LEN-1:0] pad_update;

    int total = 0;
    int bad   = 0;

    tap_port #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_tap_port (
        .tck(tck), .pwr_rst_n(pwr_rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .force_hiz(force_hiz), .pad_drive(pad_drive),
        .pad_capture(pad_capture), .pad_update(pad_update)
    );

    always #(PERIOD/2) tck = ~tck;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck); #1;
        o = tdo; e = tdo_oe; tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    // Idle -> Select-DR -> Capture-DR -> Shift-DR ... Exit1 -> Update -> Idle (R2, R3)
    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o, e;
        int oe_bad = 0;
        dout = '0;
        step(1'b1, 1'b0, o, e);
        if (e) oe_bad++;
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < n; i++) begin
            step(i == n-1, din[i], o, e);
            dout[i] = o;
            if (!e) oe_bad++;
        end
        step(1'b1, 1'b0, o, e);
        if (e) oe_bad++;
        step(1'b0, 1'b0, o, e);
        chk("R3 oe window dr", oe_bad, 0);
    endtask

    // Idle -> Select-DR -> Select-IR -> Capture-IR -> Shift-IR -> Exit1 (R2)
    task automatic shift_ir(input logic [2:0] op, input bit do_upd, output logic [2:0] cap);
        logic o, e;
        int oe_bad = 0;
        step(1'b1, 1'b0, o, e);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, op[i], o, e);
            cap[i] = o;
            if (!e) oe_bad++;
        end
        if (do_upd) begin
            step(1'b1, 1'b0, o, e);
            step(1'b0, 1'b0, o, e);
        end else begin
            step(1'b0, 1'b0, o, e);   // Pause-IR
        end
        chk("R3 oe window ir", oe_bad, 0);
    endtask

    task automatic finish_from_pause_ir();
        logic o, e;
        step(1'b1, 1'b0, o, e);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic load_op(input logic [2:0] op);
        logic [2:0] c;
        shift_ir(op, 1'b1, c);
    endtask

    task automatic five_ones_then_idle();
        logic o, e;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        chk("R1 oe low after reset", e, 1'b0);
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        logic o, e;
        chk("R1 oe at power-up", tdo_oe, 1'b0);
        chk("R6 hiz at power-up", force_hiz, 1'b0);
        chk("R6 drive at power-up", pad_drive, 1'b0);
        chk("R10 update bus at power-up", pad_update, '0);
        step(1'b0, 1'b0, o, e);
        shift_dr(32, 64'h0, d);
        chk("R6 R8 id after power-up", d[31:0], ID_EXP);
    endtask

    task automatic t_ir_capture_bypass();
        logic [2:0]  c;
        logic [63:0] d;
        logic [7:0]  pat = 8'b1011_0110;
        shift_ir(3'b111, 1'b1, c);
        chk("R4 capture pattern", c, 3'b001);
        shift_dr(8, {56'h0, pat}, d);
        chk("R9 R5 bypass 111", d[7:0], {pat[6:0], 1'b0});
    endtask

    task automatic t_reserved_codes();
        logic [2:0]  codes [3] = '{3'b011, 3'b110, 3'b101};
        logic [63:0] d;
        logic [5:0]  pat = 6'b110101;
        foreach (codes[k]) begin
            load_op(codes[k]);
            chk("R5 no hiz on bypass code", force_hiz, 1'b0);
            shift_dr(6, {58'h0, pat}, d);
            chk("R5 R9 bypass code", d[5:0], {pat[4:0], 1'b0});
        end
    endtask

    task automatic t_extest();
        logic [63:0] d;
        logic [BSR_LEN-1:0] pat = 12'hA5C;
        pad_capture = 12'h3E1;
        load_op(3'b000);
        chk("R5 extest drive", pad_drive, 1'b1);
        chk("R5 extest no hiz", force_hiz, 1'b0);
        shift_dr(BSR_LEN, {52'h0, pat}, d);
        chk("R10 extest capture", d[BSR_LEN-1:0], 12'h3E1);
        chk("R10 extest update", pad_update, pat);
    endtask

    task automatic t_hiz_and_sample();
        logic [2:0]  c;
        logic [63:0] d;
        load_op(3'b010);
        chk("R11 hiz on", force_hiz, 1'b1);
        chk("R5 hiz no drive", pad_drive, 1'b0);
        shift_ir(3'b100, 1'b0, c);
        chk("R7 hiz held before update", force_hiz, 1'b1);
        finish_from_pause_ir();
        chk("R11 hiz off after sample", force_hiz, 1'b0);
        pad_capture = 12'h5B7;
        shift_dr(BSR_LEN, 64'h0C3, d);
        chk("R5 R10 sample capture", d[BSR_LEN-1:0], 12'h5B7);
        chk("R10 sample update", pad_update, 12'h0C3);
    endtask

    task automatic t_idcode_and_hold();
        logic [63:0] d;
        load_op(3'b001);
        shift_dr(32, 64'h0, d);
        chk("R5 R8 id by opcode", d[31:0], ID_EXP);
        chk("R10 update held under id", pad_update, 12'h0C3);
        load_op(3'b111);
        shift_dr(BSR_LEN, 64'hFFF, d);
        chk("R10 update held under bypass", pad_update, 12'h0C3);
    endtask

    task automatic t_five_ones();
        logic o, e;
        logic [2:0]  c;
        logic [63:0] d;
        load_op(3'b111);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        five_ones_then_idle();
        shift_dr(32, 64'h0, d);
        chk("R1 R6 id after reset from shift-dr", d[31:0], ID_EXP);
        load_op(3'b010);
        shift_ir(3'b111, 1'b0, c);
        five_ones_then_idle();
        chk("R6 hiz cleared by reset", force_hiz, 1'b0);
        shift_dr(32, 64'h0, d);
        chk("R1 R6 id after reset from pause-ir", d[31:0], ID_EXP);
    endtask

    initial begin
        #(PERIOD*200000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge tck);
        pwr_rst_n = 1'b1;
        #1;
        t_reset();
        t_ir_capture_bypass();
        t_reserved_codes();
        t_extest();
        t_hiz_and_sample();
        t_idcode_and_hold();
        t_five_ones();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule